// File: doc/BRIEF.md
# Packed-Lane Add/Subtract Unit

This unit does add or subtract on a 64-bit word that holds several narrower integers side by side. A run-time select splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed at the same time. A carry or borrow never reaches the next lane up, so each lane behaves like a separate small adder.

Each lane can work in one of two ways. In wrap mode it drops the bits that overflow, as two's-complement arithmetic does. In saturate mode it clamps to the end of its range: the signed range or the unsigned range, chosen by a second select. The result is registered and appears one clock after the input strobe. A per-byte mask marks the lanes that were clamped.

Top module: `simd_addsub`

## Requirements
- R1: `lane_sel` sets the lane width. 2'b00 selects 8 bits, 2'b01 selects 16 bits, 2'b10 selects 32 bits, and 2'b11 behaves exactly like 2'b10. Lane k occupies bits [k*w+w-1 : k*w].
- R2: When `op_sub`=0 and `sat_en`=0, each lane returns (A+B) mod 2^w. No carry enters the lane above.
- R3: When `op_sub`=1 and `sat_en`=0, each lane returns (A-B) mod 2^w. No borrow is taken from the lane above.
- R4: When `sat_en`=1 and `sat_signed`=1, the lane operands are read as two's complement. A result above 2^(w-1)-1 becomes 2^(w-1)-1. A result below -2^(w-1) becomes -2^(w-1).
- R5: When `sat_en`=1 and `sat_signed`=0, the lane operands are read as unsigned. A result above 2^w-1 becomes all ones. A result below zero becomes zero.
- R6: Bit i of `out_sat_mask` covers byte i of the word. It is set when the lane holding byte i was clamped, so every byte of a lane carries the same value. The mask is all zero in wrap mode, where `sat_signed` has no effect on the result.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. The result and mask for that input appear at the same time.
- R8: Synchronous active-high `rst` clears `out_valid`, `out_data` and `out_sat_mask` to zero.
- R9: When `in_valid` is low, `out_data` and `out_sat_mask` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| lane_sel | input | 2 | Lane width select |
| op_sub | input | 1 | 1 = A minus B, 0 = A plus B |
| sat_en | input | 1 | 1 = saturate, 0 = wrap |
| sat_signed | input | 1 | Saturation range: 1 = signed, 0 = unsigned |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Packed result |
| out_sat_mask | output | 8 | Per-byte clamp flags |

## Verification
The bench builds the unit with its default parameters: a 64-bit word cut into 8-bit slices. With these values every lane width gives at least two lanes, so a carry or borrow that leaks across a lane boundary shows up in the result. Directed vectors cover the edges of every lane width: signed saturation in both directions, unsigned overflow and underflow, a carry that would cross a boundary, and the spare lane-select code. Randomised vectors with idle gaps between them exercise the hold and timing behaviour.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
   typedef enum logic [1:0] {
      LANE_8   = 2'b00,
      LANE_16  = 2'b01,
      LANE_32  = 2'b10,
      LANE_32X = 2'b11
   } lane_sel_e;

   // number of slices per lane for a select code
   function automatic int slices_per_lane(input lane_sel_e s);
      case (s)
         LANE_8:  return 1;
         LANE_16: return 2;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf_s
);
   logic [W-1:0] b_eff;

   always_comb begin
      b_eff        = b ^ {W{sub}};
      {cout, sum}  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      ovf_s        = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/simd_lane_map.sv
module simd_lane_map
   import simd_addsub_pkg::*;
#(
   parameter int NSLICE = 8,
   localparam int IDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
   input  logic [1:0]       lane_sel,
   output logic [NSLICE-1:0] first,
   output logic [IDX_W-1:0]  top_idx [NSLICE]
);
   generate
      for (genvar i = 0; i < NSLICE; i++) begin : g_map
         always_comb begin
            int span;
            span       = slices_per_lane(lane_sel_e'(lane_sel));
            first[i]   = ((i % span) == 0);
            top_idx[i] = IDX_W'(i - (i % span) + span - 1);
         end
      end
   endgenerate
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
   import simd_addsub_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int SLICE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [WORD_W-1:0]          op_a,
   input  logic [WORD_W-1:0]          op_b,
   input  logic [1:0]                 lane_sel,
   input  logic                       op_sub,
   input  logic                       sat_en,
   input  logic                       sat_signed,
   output logic                       out_valid,
   output logic [WORD_W-1:0]          out_data,
   output logic [WORD_W/SLICE_W-1:0]  out_sat_mask
);
   localparam int NSLICE = WORD_W / SLICE_W;
   localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;

   generate
      if (WORD_W % (SLICE_W * 4) != 0) begin : g_bad_width
         $error("WORD_W must be a multiple of 4*SLICE_W");
      end
      if (SLICE_W < 2) begin : g_bad_slice
         $error("SLICE_W must be at least 2");
      end
   endgenerate

   logic [NSLICE-1:0]  first;
   logic [IDX_W-1:0]   top_idx [NSLICE];
   logic [NSLICE:0]    carry;
   logic [NSLICE-1:0]  cin;
   logic [NSLICE-1:0]  ovf_s;
   logic [NSLICE-1:0]  ovf_u;
   logic [SLICE_W-1:0] raw  [NSLICE];
   logic [SLICE_W-1:0] fin  [NSLICE];
   logic [NSLICE-1:0]  hit;
   logic [WORD_W-1:0]  res_w;

   simd_lane_map #(.NSLICE(NSLICE)) u_map (
      .lane_sel (lane_sel),
      .first    (first),
      .top_idx  (top_idx)
   );

   assign carry[0] = op_sub;

   generate
      for (genvar i = 0; i < NSLICE; i++) begin : g_slice
         assign cin[i] = first[i] ? op_sub : carry[i];

         simd_slice_add #(.W(SLICE_W)) u_add (
            .a     (op_a[i*SLICE_W +: SLICE_W]),
            .b     (op_b[i*SLICE_W +: SLICE_W]),
            .sub   (op_sub),
            .cin   (cin[i]),
            .sum   (raw[i]),
            .cout  (carry[i+1]),
            .ovf_s (ovf_s[i])
         );

         // unsigned: carry-out on add, missing carry on subtract
         assign ovf_u[i] = op_sub ? ~carry[i+1] : carry[i+1];

         always_comb begin
            logic [IDX_W-1:0] t;
            logic             neg;
            t      = top_idx[i];
            neg    = op_a[int'(t)*SLICE_W + SLICE_W - 1];
            hit[i] = sat_en && (sat_signed ? ovf_s[t] : ovf_u[t]);
            fin[i] = raw[i];
            if (hit[i]) begin
               if (sat_signed)
                  fin[i] = (int'(t) == i) ? {neg, {(SLICE_W-1){~neg}}}
                                          : {SLICE_W{~neg}};
               else
                  fin[i] = {SLICE_W{~op_sub}};
            end
         end

         assign res_w[i*SLICE_W +: SLICE_W] = fin[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_sat_mask <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data     <= res_w;
            out_sat_mask <= hit;
         end
      end
   end

   // R7: result valid exactly one cycle after the strobe
   a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R9: idle cycles keep the result
   a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data) && $stable(out_sat_mask));
   // R6: wrap mode never flags saturation
   a_r6_wrap_no_mask: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sat_en) |=> (out_sat_mask == '0));

   generate
      for (genvar p = 0; p < NSLICE; p += 2) begin : g_pair_chk
         // R6: both bytes of a 16-bit lane carry the same flag
         a_r6_pair_uniform: assert property (@(posedge clk) disable iff (rst)
            (in_valid && lane_sel == LANE_16) |=>
               (out_sat_mask[p] == out_sat_mask[p+1]));
      end
   endgenerate
endmodule

// File: tb/simd_addsub_bench.sv
`timescale 1ns/1ps
module simd_addsub_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] op_a, op_b;
   logic [1:0]  lane_sel;
   logic        op_sub, sat_en, sat_signed;
   logic        out_valid;
   logic [63:0] out_data;
   logic [7:0]  out_sat_mask;

   int n_checks = 0;
   int n_fail   = 0;

   logic        exp_valid;
   logic [63:0] exp_data;
   logic [7:0]  exp_mask;

   always #2.5 clk = ~clk;

   simd_addsub u_simd_addsub (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .op_a         (op_a),
      .op_b         (op_b),
      .lane_sel     (lane_sel),
      .op_sub       (op_sub),
      .sat_en       (sat_en),
      .sat_signed   (sat_signed),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_sat_mask (out_sat_mask)
   );

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference for one operation
   task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sel,
                        input logic sub, input logic sat, input logic sgn,
                        output logic [63:0] r, output logic [7:0] m);
      int w;
      w = (sel == 2'b00) ? 8 : (sel == 2'b01) ? 16 : 32;
      r = '0;
      m = '0;
      for (int j = 0; j < 64 / w; j++) begin
         longint la, lb, lr, lo, hi, full;
         logic clamped;
         full = longint'(1) << w;
         la = longint'((a >> (j * w)) & 64'(full - 1));
         lb = longint'((b >> (j * w)) & 64'(full - 1));
         if (sat && sgn) begin
            if (la >= full / 2) la = la - full;
            if (lb >= full / 2) lb = lb - full;
         end
         lr = sub ? la - lb : la + lb;
         clamped = 1'b0;
         if (sat) begin
            lo = sgn ? -(full / 2) : 0;
            hi = sgn ? (full / 2) - 1 : full - 1;
            if (lr > hi) begin lr = hi; clamped = 1'b1; end
            if (lr < lo) begin lr = lo; clamped = 1'b1; end
         end
         lr = lr & (full - 1);
         r = r | (64'(lr) << (j * w));
         if (clamped)
            for (int k = 0; k < w / 8; k++) m[j * (w / 8) + k] = 1'b1;
      end
   endtask

   task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] sel, input logic sub, input logic sat, input logic sgn);
      string tag;
      logic [63:0] r;
      logic [7:0]  m;
      @(negedge clk);
      in_valid = v; op_a = a; op_b = b; lane_sel = sel;
      op_sub = sub; sat_en = sat; sat_signed = sgn;
      exp_valid = v;
      if (v) begin
         model(a, b, sel, sub, sat, sgn, r, m);
         exp_data = r;
         exp_mask = m;
      end
      if (!v)              tag = "R9";
      else if (sel == 2'b11) tag = "R1";
      else if (sat && sgn) tag = "R4";
      else if (sat)        tag = "R5";
      else if (sub)        tag = "R3";
      else                 tag = "R2";
      @(posedge clk);
      #1;
      check64("R7 valid", 64'(out_valid), 64'(exp_valid));
      check64(tag, out_data, exp_data);
      check64("R6 mask", 64'(out_sat_mask), 64'(exp_mask));
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
      lane_sel = 2'b00; op_sub = 1'b0; sat_en = 1'b0; sat_signed = 1'b0;
      exp_valid = 1'b0; exp_data = '0; exp_mask = '0;
      repeat (3) @(posedge clk);
      #1;
      check64("R8 valid", 64'(out_valid), 64'd0);
      check64("R8 data",  out_data, 64'd0);
      check64("R8 mask",  64'(out_sat_mask), 64'd0);
      @(negedge clk);
      rst = 1'b0;

      // R2: 8-bit carries stay inside lanes
      step(1, 64'hFF01_7F80_00FF_FFFF, 64'h0101_0180_0001_0101, 2'b00, 0, 0, 0);
      // R2: 16-bit carry from low byte to high byte, not beyond
      step(1, 64'hFFFF_00FF_7FFF_1234, 64'h0001_0001_0001_1111, 2'b01, 0, 0, 0);
      // R3: 32-bit borrow stays inside lanes
      step(1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'b10, 1, 0, 0);
      // R6: sat_signed ignored in wrap mode
      step(1, 64'h7F7F_7F7F_8080_8080, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 1);
      // R4: signed clamp both ways, 8-bit
      step(1, 64'h7F80_7F80_0102_7F80, 64'h0101_01FF_0101_7F01, 2'b00, 0, 1, 1);
      step(1, 64'h8000_7FFF_0000_1234, 64'h0001_FFFF_8000_0001, 2'b01, 1, 1, 1);
      step(1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'b10, 0, 1, 1);
      step(1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'b10, 1, 1, 1);
      // R5: unsigned overflow to ones, underflow to zero
      step(1, 64'hFFFE_FF00_1234_00FF, 64'h0003_0100_0001_0001, 2'b00, 0, 1, 0);
      step(1, 64'h0000_0005_FFFF_0001, 64'h0001_0003_0001_0002, 2'b01, 1, 1, 0);
      step(1, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 2'b10, 0, 1, 0);
      step(1, 64'h0000_0001_0000_0001, 64'h0000_0002_0000_0001, 2'b10, 1, 1, 0);
      // R1: code 11 behaves as 32-bit lanes
      step(1, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b11, 0, 0, 0);
      step(1, 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 2'b11, 0, 1, 1);
      // R9: idle cycles hold the last result
      step(0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'b00, 0, 1, 0);
      step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 1, 1, 1);

      // random mix with idle gaps
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r0, r1, r2, r3, r4;
         r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom; r4 = $urandom;
         step((r4[3:0] != 0), {r0, r1}, {r2, r3}, r4[5:4], r4[6], r4[7], r4[8]);
      end

      // R8: reset after activity clears outputs
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b1;
      @(posedge clk);
      #1;
      check64("R8 valid", 64'(out_valid), 64'd0);
      check64("R8 data",  out_data, 64'd0);
      check64("R8 mask",  64'(out_sat_mask), 64'd0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule